// File: doc/BRIEF.md
# Dual Masked Alarm Comparator with Interrupt Pulse

This block holds two independent alarm settings for a real-time clock. Each setting has six time fields (second, minute, hour, date, month, day of week), and each field carries its own enable flag in bit 7. On every one-second tick the block compares each alarm against the live time. Only the enabled fields take part in the comparison, so one setting can express "every minute at second 45", "every Wednesday at 08:00" or "once a year on a given date". An alarm with no enabled field never fires.

Every match sets that alarm's status flag. If the alarm's interrupt enable is set, the block also drives an active-low interrupt for a fixed number of system clock cycles. The output is modelled as the enable of an open-drain pull-down. Without repeat mode an alarm pulses only on its first match after it is armed. With repeat mode it pulses on every match. The host clears the flags through a two-event status-read handshake. A flag that becomes set while a read is in progress survives that read.

Each pulse generator is a three-state machine: `PG_IDLE` (armed), `PG_PULSE` (driving the pad) and `PG_SPENT` (fired once, waiting). Its transitions are as follows:
- idle to pulse on a match with the interrupt enabled.
- pulse to idle at the end of the count when repeat mode is on.
- pulse to spent at the end of the count when repeat mode is off.
- spent to idle on a rearm or when repeat mode is on.

The status reader has two states, `RD_IDLE` and `RD_ACTIVE`. Its transitions are as follows:
- idle to active on a read start, which snapshots the flags.
- active to idle on the read-done event, which clears only the snapshotted flags.

Register map (4-bit address):
- 0 to 5: the fields of alarm 0, in the order second, minute, hour, date, month, day.
- 8 to 13: the same fields for alarm 1.
- 7: control. Bit 0 is the alarm 0 interrupt enable, bit 1 is the alarm 1 interrupt enable and bit 2 is repeat mode.
- 15: status. It reads {6'b0, flag1, flag0}.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset all alarm fields and the control register read 0, both flags are 0 and the interrupt pull-down enable is 0.
- R2: A write to addresses 0 to 5, 8 to 13 or 7 is read back at the same address (control keeps bits 2:0 only). A write to addresses 6, 14 or 15 has no effect, and addresses 6 and 14 read 0.
- R3: A field takes part in the match only when its bit 7 is 1. Disabled fields may differ from the live time and the alarm still fires.
- R4: An alarm whose six enable bits are all 0 never sets its flag.
- R5: A match sets the alarm's flag (status bit 0 for alarm 0, bit 1 for alarm 1) whether or not its interrupt enable is set. The pull-down is driven only for alarms whose enable is 1.
- R6: A match with the interrupt enabled drives the pull-down starting in the cycle after the tick, for exactly PULSE_CYCLES cycles.
- R7: Without repeat mode an alarm pulses only on its first match after being armed. Any write to that alarm's fields or to the control register arms it again.
- R8: With repeat mode every match of an alarm produces a new pulse.
- R9: Only the low bits of each field are compared: 7 bits for seconds and minutes, 6 for hour and date, 5 for month and 3 for day of week. Hours are compared as a 0 to 23 value with no 12/24 select bit.
- R10: A status read clears on its done event only the flags that were set at its start event. A flag set during the read stays set.
- R11: When a match and the read-done event fall in the same cycle, the matching alarm's flag remains set.
- R12: Without a tick, equal time values set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe once per second; live time valid |
| now_sec | input | 7 | Live seconds, BCD |
| now_min | input | 7 | Live minutes, BCD |
| now_hour | input | 7 | Live hour, BCD 0 to 23 |
| now_date | input | 7 | Live day of month, BCD |
| now_month | input | 7 | Live month, BCD |
| now_dow | input | 7 | Live day of week, 0 to 6 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| stat_rd_start | input | 1 | Status read begins; flags are snapshotted |
| stat_rd_done | input | 1 | Status read ends; snapshotted flags clear |
| alarm_flags | output | 2 | Alarm status flags {alarm1, alarm0} |
| irq_drive_low | output | 1 | 1 = pull the open-drain interrupt pad low |

## Verification
Two functions can land in the same cycle: a new match setting a flag and a status read's done event clearing it. The bench provokes this by raising `tick_1hz` on a matching time in exactly the cycle where `stat_rd_done` is high after a snapshot that already held the flag. It judges the result by seeing the flag still set at the status address. A second provocation places a match between start and done for the other alarm, and expects that flag to outlive the read while the snapshotted one is cleared. The enable masks are swept exhaustively: all 64 masks, each with one chosen field disturbed or none.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

    localparam int FIELD_COUNT = 6;
    localparam int FIELD_W     = 7;
    localparam int FIELD_IDX_W = 3;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd7;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd15;

    localparam int CTRL_REPEAT = 2;

    typedef enum logic [1:0] {
        PG_IDLE  = 2'd0,
        PG_PULSE = 2'd1,
        PG_SPENT = 2'd2
    } pulse_state_e;

    typedef enum logic {
        RD_IDLE   = 1'b0,
        RD_ACTIVE = 1'b1
    } read_state_e;

    // Significant bits of each time field: sec, min, hour, date, month, dow
    function automatic logic [FIELD_W-1:0] field_mask(input int unsigned f);
        case (f)
            0, 1:    field_mask = 7'h7F;
            2, 3:    field_mask = 7'h3F;
            4:       field_mask = 7'h1F;
            default: field_mask = 7'h07;
        endcase
    endfunction

endpackage

// File: rtl/alarm_compare.sv
module alarm_compare
    import alarm_match_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [FIELD_IDX_W-1:0]         field_sel,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [DATA_W-1:0]              rd_data,
    input  logic [FIELD_COUNT*FIELD_W-1:0] now_vec,
    input  logic                           tick,
    output logic                           fire
);

    logic [DATA_W-1:0] fld_q [FIELD_COUNT];
    logic              any_en;
    logic              all_eq;

    for (genvar f = 0; f < FIELD_COUNT; f++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fld_q[f] <= '0;
            end else if (wr_en && field_sel == FIELD_IDX_W'(f)) begin
                fld_q[f] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int f = 0; f < FIELD_COUNT; f++) begin
            if (field_sel == FIELD_IDX_W'(f)) begin
                rd_data = fld_q[f];
            end
        end
    end

    always_comb begin
        any_en = 1'b0;
        all_eq = 1'b1;
        for (int f = 0; f < FIELD_COUNT; f++) begin
            if (fld_q[f][DATA_W-1]) begin
                any_en = 1'b1;
                if (((fld_q[f][FIELD_W-1:0] ^ now_vec[f*FIELD_W +: FIELD_W])
                     & field_mask(f)) != '0) begin
                    all_eq = 1'b0;
                end
            end
        end
    end

    assign fire = tick && any_en && all_eq;

endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
    import alarm_match_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic int_en,
    input  logic repeat_mode,
    input  logic rearm,
    output logic pulse_active
);

    localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

    pulse_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_IDLE:  if (fire && int_en) state_d = PG_PULSE;
            PG_PULSE: if (cnt_q == '0) state_d = repeat_mode ? PG_IDLE : PG_SPENT;
            PG_SPENT: if (rearm || repeat_mode) state_d = PG_IDLE;
            default:  state_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == PG_IDLE) begin
            cnt_q <= CNT_LOAD;
        end else if (state_q == PG_PULSE && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        pulse_active = (state_q == PG_PULSE);
    end

endmodule

// File: rtl/status_flags.sv
module status_flags
    import alarm_match_pkg::*;
#(
    parameter int NUM_ALARMS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_ALARMS-1:0] set_vec,
    input  logic                  rd_start,
    input  logic                  rd_done,
    output logic [NUM_ALARMS-1:0] flags
);

    read_state_e           state_q, state_d;
    logic [NUM_ALARMS-1:0] snap_q, snap_d;
    logic [NUM_ALARMS-1:0] flags_q, flags_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            snap_q  <= '0;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            snap_q  <= snap_d;
            flags_q <= flags_d;
        end
    end

    always_comb begin
        state_d = state_q;
        snap_d  = snap_q;
        flags_d = flags_q;
        unique case (state_q)
            RD_IDLE: ;
            RD_ACTIVE: begin
                if (rd_done) begin
                    flags_d = flags_q & ~snap_q;
                    snap_d  = '0;
                    state_d = RD_IDLE;
                end
            end
            default: state_d = RD_IDLE;
        endcase
        if (rd_start) begin
            snap_d  = flags_q;
            state_d = RD_ACTIVE;
        end
        flags_d = flags_d | set_vec;
    end

    assign flags = flags_q;

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_match_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic [6:0]  now_sec,
    input  logic [6:0]  now_min,
    input  logic [6:0]  now_hour,
    input  logic [6:0]  now_date,
    input  logic [6:0]  now_month,
    input  logic [6:0]  now_dow,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        stat_rd_start,
    input  logic        stat_rd_done,
    output logic [1:0]  alarm_flags,
    output logic        irq_drive_low
);

    localparam int NUM_ALARMS = 2;
    localparam int CTRL_W     = NUM_ALARMS + 1;

    logic [FIELD_COUNT*FIELD_W-1:0] now_vec;
    logic [CTRL_W-1:0]              ctrl_q;
    logic [NUM_ALARMS-1:0]          fire_vec;
    logic [NUM_ALARMS-1:0]          pulse_vec;
    logic [NUM_ALARMS-1:0]          rearm_vec;
    logic [DATA_W-1:0]              set_rdata [NUM_ALARMS];
    logic                           field_addr;
    logic                           ctrl_wr;

    assign now_vec    = {now_dow, now_month, now_date, now_hour, now_min, now_sec};
    assign field_addr = (reg_addr[FIELD_IDX_W-1:0] < FIELD_IDX_W'(FIELD_COUNT));
    assign ctrl_wr    = reg_wr && (reg_addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= reg_wdata[CTRL_W-1:0];
        end
    end

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        logic set_hit;
        assign set_hit      = (reg_addr[ADDR_W-1] == 1'(a)) && field_addr;
        assign rearm_vec[a] = (reg_wr && set_hit) || ctrl_wr;

        alarm_compare u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_wr && set_hit),
            .field_sel (reg_addr[FIELD_IDX_W-1:0]),
            .wr_data   (reg_wdata),
            .rd_data   (set_rdata[a]),
            .now_vec   (now_vec),
            .tick      (tick_1hz),
            .fire      (fire_vec[a])
        );

        irq_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
            .clk          (clk),
            .rst_n        (rst_n),
            .fire         (fire_vec[a]),
            .int_en       (ctrl_q[a]),
            .repeat_mode  (ctrl_q[CTRL_REPEAT]),
            .rearm        (rearm_vec[a]),
            .pulse_active (pulse_vec[a])
        );
    end

    status_flags #(.NUM_ALARMS(NUM_ALARMS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (fire_vec),
        .rd_start (stat_rd_start),
        .rd_done  (stat_rd_done),
        .flags    (alarm_flags)
    );

    always_comb begin
        if (reg_addr == ADDR_STATUS) begin
            reg_rdata = {{(DATA_W-NUM_ALARMS){1'b0}}, alarm_flags};
        end else if (reg_addr == ADDR_CTRL) begin
            reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        end else if (field_addr) begin
            reg_rdata = set_rdata[reg_addr[ADDR_W-1]];
        end else begin
            reg_rdata = '0;
        end
    end

    assign irq_drive_low = |pulse_vec;

endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       stat_rd_done,
    input logic [1:0] fire,
    input logic [1:0] alarm_flags,
    input logic       irq_drive_low
);

    // R12: a flag only rises after a tick
    p_flag_needs_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flags[0]) || $rose(alarm_flags[1]) |-> $past(tick_1hz));

    // R6: a pulse starts only in the cycle after a tick
    p_irq_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_drive_low) |-> $past(tick_1hz));

    // R5: a starting pulse comes with its alarm's flag
    p_irq_with_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_drive_low) |-> (alarm_flags != 2'b00));

    // R10: a flag only falls after a read-done event
    p_clear_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flags[0]) || $fell(alarm_flags[1]) |-> $past(stat_rd_done));

    // R11: a match coinciding with read-done leaves the flag set
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_done && fire[0] |=> alarm_flags[0]);

endmodule

bind alarm_match_unit alarm_match_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_1hz      (tick_1hz),
    .stat_rd_done  (stat_rd_done),
    .fire          (fire_vec),
    .alarm_flags   (alarm_flags),
    .irq_drive_low (irq_drive_low)
);

// File: tb/alarm_match_unit_test.sv
`timescale 1ns/1ps
module alarm_match_unit_test;

    localparam int PULSE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [6:0] now_sec = '0, now_min = '0, now_hour = '0;
    logic [6:0] now_date = '0, now_month = '0, now_dow = '0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       stat_rd_start = 1'b0, stat_rd_done = 1'b0;
    logic [1:0] alarm_flags;
    logic       irq_drive_low;

    int checks = 0;
    int fails  = 0;

    logic [6:0] vals [6] = '{7'h45, 7'h30, 7'h21, 7'h15, 7'h03, 7'h02};

    always #10 clk = ~clk;

    alarm_match_unit #(.PULSE_CYCLES(PULSE)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_date(now_date), .now_month(now_month), .now_dow(now_dow),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .stat_rd_start(stat_rd_start),
        .stat_rd_done(stat_rd_done), .alarm_flags(alarm_flags),
        .irq_drive_low(irq_drive_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic status_read();
        @(negedge clk); stat_rd_start = 1'b1;
        @(negedge clk); stat_rd_start = 1'b0;
        @(negedge clk); stat_rd_done = 1'b1;
        @(negedge clk); stat_rd_done = 1'b0;
    endtask

    task automatic set_now(input int diff);
        now_sec   = vals[0] ^ ((diff == 0) ? 7'h01 : 7'h00);
        now_min   = vals[1] ^ ((diff == 1) ? 7'h01 : 7'h00);
        now_hour  = vals[2] ^ ((diff == 2) ? 7'h01 : 7'h00);
        now_date  = vals[3] ^ ((diff == 3) ? 7'h01 : 7'h00);
        now_month = vals[4] ^ ((diff == 4) ? 7'h01 : 7'h00);
        now_dow   = vals[5] ^ ((diff == 5) ? 7'h01 : 7'h00);
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (irq_drive_low && n < 4 * PULSE) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic clear_fields();
        for (int f = 0; f < 6; f++) begin
            wr(4'(f), 8'h00);
            wr(4'(f + 8), 8'h00);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 flags", alarm_flags, 0);
        chk("R1 irq", irq_drive_low, 0);
        rd(4'd2, d);  chk("R1 field", d, 0);
        rd(4'd7, d);  chk("R1 ctrl", d, 0);

        // R2 read-back and ignored addresses
        for (int a = 0; a < 16; a++) begin
            if (a != 7 && a != 15) wr(4'(a), 8'(8'h11 * a + 8'h07));
        end
        for (int a = 0; a < 15; a++) begin
            rd(4'(a), d);
            if (a == 6 || a == 14) chk("R2 hole", d, 0);
            else if (a != 7)       chk("R2 field", d, 8'(8'h11 * a + 8'h07));
        end
        wr(4'd7, 8'hFA);
        rd(4'd7, d); chk("R2 ctrl", d, 8'h02);
        wr(4'd15, 8'hFF);
        rd(4'd15, d); chk("R2 status write ignored", d, 0);
        clear_fields();
        wr(4'd7, 8'h00);

        // R3/R4 exhaustive mask sweep on alarm 0
        for (int m = 0; m < 64; m++) begin
            for (int f = 0; f < 6; f++) wr(4'(f), {m[f], 7'(vals[f])});
            for (int diff = 0; diff <= 6; diff++) begin
                set_now(diff);
                tick();
                if (m == 0) chk("R4 no enables", alarm_flags[0], 0);
                else chk("R3 masked match", alarm_flags[0],
                         (diff == 6 || !m[diff]) ? 1 : 0);
                status_read();
            end
        end
        clear_fields();

        // R12 equal time without tick
        wr(4'd0, 8'hC5);
        set_now(6);
        repeat (5) @(negedge clk);
        chk("R12 no tick", alarm_flags, 0);

        // R9 upper bits ignored, hour as 0..23
        wr(4'd0, 8'h00);
        wr(4'd2, 8'hA1);
        now_hour = 7'h61;
        tick(); chk("R9 hour bit6 ignored", alarm_flags[0], 1);
        status_read();
        now_hour = 7'h20;
        tick(); chk("R9 hour mismatch", alarm_flags[0], 0);
        wr(4'd2, 8'h00);
        wr(4'd5, 8'h82);
        now_dow = 7'h7A;
        tick(); chk("R9 dow 3 bits", alarm_flags[0], 1);
        status_read();
        wr(4'd5, 8'h00);
        set_now(6);

        // R5 flag without interrupt
        wr(4'd0, 8'hC5);
        tick();
        chk("R5 flag set", alarm_flags[0], 1);
        chk("R5 no irq when disabled", irq_drive_low, 0);
        status_read();

        // R6 pulse length on alarm 0
        wr(4'd7, 8'h01);
        tick();
        chk("R6 irq starts", irq_drive_low, 1);
        pulse_len(n); chk("R6 pulse length", n, PULSE);

        // R7 single-shot until rearm
        status_read();
        tick();
        chk("R7 flag on second match", alarm_flags[0], 1);
        chk("R7 no second pulse", irq_drive_low, 0);
        wr(4'd0, 8'hC5);
        tick();
        chk("R7 pulse after rearm", irq_drive_low, 1);
        pulse_len(n);

        // R8 repeat mode
        wr(4'd7, 8'h05);
        tick(); pulse_len(n); chk("R8 first pulse", n, PULSE);
        tick(); pulse_len(n); chk("R8 second pulse", n, PULSE);
        tick(); chk("R8 third pulse", irq_drive_low, 1);
        pulse_len(n);

        // R5 alarm 1 with interrupt, alarm 0 without
        wr(4'd7, 8'h02);
        wr(4'd8, 8'hC5);
        status_read();
        tick();
        chk("R5 both flags", alarm_flags, 3);
        chk("R5 alarm1 irq", irq_drive_low, 1);
        pulse_len(n);
        wr(4'd8, 8'h00);
        wr(4'd7, 8'h00);

        // R10 flag set mid-read survives
        wr(4'd9, 8'hB0);
        status_read();
        now_sec = 7'h45; now_min = 7'h00;
        tick();
        chk("R10 only alarm0", alarm_flags, 1);
        @(negedge clk); stat_rd_start = 1'b1;
        @(negedge clk); stat_rd_start = 1'b0;
        now_sec = 7'h00; now_min = 7'h30;
        tick();
        @(negedge clk); stat_rd_done = 1'b1;
        @(negedge clk); stat_rd_done = 1'b0;
        rd(4'd15, d); chk("R10 snapshot clear", d, 8'h02);

        // R11 match in the done cycle
        status_read();
        now_sec = 7'h45; now_min = 7'h00;
        tick();
        @(negedge clk); stat_rd_start = 1'b1;
        @(negedge clk); stat_rd_start = 1'b0;
        @(negedge clk); stat_rd_done = 1'b1; tick_1hz = 1'b1;
        @(negedge clk); stat_rd_done = 1'b0; tick_1hz = 1'b0;
        rd(4'd15, d); chk("R11 set wins over clear", d, 8'h01);
        status_read();
        rd(4'd15, d); chk("R11 later clear", d, 8'h00);

        summary();
        $finish;
    end

endmodule